// File: doc/BRIEF.md
# Configurable Register-Type Output Macrocell Bank

This block models the output macrocells of a programmable logic device. Each cell receives two precomputed sum-of-products terms and one special-function product term from an array that lies outside the block. Static configuration bits set four things for each cell: whether the cell is combinatorial, a register on its bank clock, or a register clocked on its own; which storage function the flip-flop performs (D, T, JK or SR); whether the pin value is inverted; and what the cell feeds back to the array.

The special-function product term serves one of two purposes. In combinatorial or bank-clocked register mode it drives the cell's output enable. In the per-cell clock mode it becomes that cell's clock, and the output is then always enabled. The cells are grouped into banks of equal size. Each bank has its own clock input, which all bank-clocked cells of that bank share. A single asynchronous reset clears every register.

Top module: `pld_macro_bank`

## Requirements
- R1: With type code 2'b00 (D), a clock edge loads the register from sumA.
- R2: With type code 2'b01 (T), a clock edge inverts the register when sumA is 1 and leaves it unchanged when sumA is 0.
- R3: With type code 2'b10 (JK, J=sumA, K=sumB), a clock edge holds on 00, sets on J only, clears on K only, and toggles on 11.
- R4: With type code 2'b11 (SR, S=sumA, R=sumB), a clock edge sets on S only and clears on R only; it holds on 00 and also on 11.
- R5: Mode code bit 1 clear (2'b00 combinatorial, 2'b01 bank register): cell i is clocked by the rising edge of bankClk[i/BANK_SIZE] only. An edge on any other bank clock leaves cell i unchanged.
- R6: Mode code bit 1 set (per-cell clock): the rising edge of specialPt[i] clocks only cell i, bank clock edges have no effect on it, and pinOe[i] is 1.
- R7: In modes 2'b00 and 2'b01, pinOe[i] equals specialPt[i].
- R8: In mode 2'b00, pinOut[i] follows sumA[i] (after polarity) with no clock, while the register itself keeps updating on its bank clock.
- R9: cfgInvert[i]=1 inverts pinOut[i]; the feedback is never inverted.
- R10: cfgFbSum[i]=0 puts the register state on fbOut[i]; cfgFbSum[i]=1 puts sumA[i] there.
- R11: rstIn high clears every register to 0 without any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstIn | input | 1 | Asynchronous reset, active high |
| bankClk | input | NUM_CELLS/BANK_SIZE | One clock per bank |
| sumA | input | NUM_CELLS | First sum term per cell (D, T, J or S) |
| sumB | input | NUM_CELLS | Second sum term per cell (K or R) |
| specialPt | input | NUM_CELLS | Special-function product term per cell |
| cfgMode | input | 2*NUM_CELLS | Mode code per cell |
| cfgType | input | 2*NUM_CELLS | Storage type code per cell |
| cfgInvert | input | NUM_CELLS | Pin polarity inversion per cell |
| cfgFbSum | input | NUM_CELLS | Feedback source select per cell |
| pinOut | output | NUM_CELLS | Value driven to the pin |
| pinOe | output | NUM_CELLS | Pin output enable |
| fbOut | output | NUM_CELLS | Feedback to the array |

## Verification
The bench drives JK with 11 and SR with 11 together in one vector. A design that merged the two types would toggle the SR cells there instead of holding them. It clocks one bank alone, which exposes a design that wires both banks to the same clock. It moves one cell to per-cell clocking and then pulses the bank clocks. A design that left that cell on the bank clock, or still gated its output enable, would show a changed register or a low enable. The bench also flips the polarity and feedback selects, so a design that inverts the feedback together with the pin, or lets a combinatorial cell wait for a clock, gives wrong values at the ports.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    REG_D  = 2'b00,
    REG_T  = 2'b01,
    REG_JK = 2'b10,
    REG_SR = 2'b11
  } regKind_e;

  // strobes from control to datapath, at most one of set/clr/tgl active
  typedef struct packed {
    logic doSet;
    logic doClr;
    logic doTgl;
    logic passComb;
  } mcStrobe_t;
endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic [1:0] modeCfg,
  input  logic [1:0] typeCfg,
  input  logic       sumA,
  input  logic       sumB,
  input  logic       specialPt,
  input  logic       bankClk,
  output logic       cellClk,
  output logic       outEn,
  output mcStrobe_t  strobe
);
  logic asyncReg;
  logic regMode;

  assign asyncReg = modeCfg[1];
  assign regMode  = modeCfg[1] | modeCfg[0];

  // special term steered to clock or to output enable
  assign cellClk = asyncReg ? specialPt : bankClk;
  assign outEn   = asyncReg ? 1'b1 : specialPt;

  always_comb begin
    strobe = '0;
    strobe.passComb = ~regMode;
    case (regKind_e'(typeCfg))
      REG_D: begin
        strobe.doSet = sumA;
        strobe.doClr = ~sumA;
      end
      REG_T: begin
        strobe.doTgl = sumA;
      end
      REG_JK: begin
        strobe.doSet = sumA & ~sumB;
        strobe.doClr = ~sumA & sumB;
        strobe.doTgl = sumA & sumB;
      end
      default: begin
        strobe.doSet = sumA & ~sumB;
        strobe.doClr = ~sumA & sumB;
      end
    endcase
  end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
(
  input  logic      cellClk,
  input  logic      rstIn,
  input  mcStrobe_t strobe,
  input  logic      sumA,
  input  logic      invertCfg,
  input  logic      fbSumCfg,
  output logic      pinVal,
  output logic      fbVal
);
  logic qBit;
  logic dataBit;

  always_ff @(posedge cellClk or posedge rstIn) begin
    if (rstIn)             qBit <= 1'b0;
    else if (strobe.doSet) qBit <= 1'b1;
    else if (strobe.doClr) qBit <= 1'b0;
    else if (strobe.doTgl) qBit <= ~qBit;
  end

  assign dataBit = strobe.passComb ? sumA : qBit;
  assign pinVal  = dataBit ^ invertCfg;
  assign fbVal   = fbSumCfg ? sumA : qBit;

  always_comb begin
    if (rstIn == 1'b0) begin
      assert_strobe_excl_R3: assert ($onehot0({strobe.doSet, strobe.doClr, strobe.doTgl}));
    end
  end

  assert_set_R4: assert property (@(posedge cellClk) disable iff (rstIn)
    strobe.doSet |=> qBit);
  assert_clear_R1: assert property (@(posedge cellClk) disable iff (rstIn)
    strobe.doClr |=> !qBit);
  assert_toggle_R2: assert property (@(posedge cellClk) disable iff (rstIn)
    strobe.doTgl |=> (qBit != $past(qBit)));
  assert_hold_R4: assert property (@(posedge cellClk) disable iff (rstIn)
    !(strobe.doSet | strobe.doClr | strobe.doTgl) |=> $stable(qBit));
endmodule

// File: rtl/pld_macro_bank.sv
module pld_macro_bank
  import mc_pkg::*;
#(
  parameter int NUM_CELLS = 16,
  parameter int BANK_SIZE = 8,
  localparam int NUM_BANKS = NUM_CELLS / BANK_SIZE
) (
  input  logic                   rstIn,
  input  logic [NUM_BANKS-1:0]   bankClk,
  input  logic [NUM_CELLS-1:0]   sumA,
  input  logic [NUM_CELLS-1:0]   sumB,
  input  logic [NUM_CELLS-1:0]   specialPt,
  input  logic [2*NUM_CELLS-1:0] cfgMode,
  input  logic [2*NUM_CELLS-1:0] cfgType,
  input  logic [NUM_CELLS-1:0]   cfgInvert,
  input  logic [NUM_CELLS-1:0]   cfgFbSum,
  output logic [NUM_CELLS-1:0]   pinOut,
  output logic [NUM_CELLS-1:0]   pinOe,
  output logic [NUM_CELLS-1:0]   fbOut
);
  for (genvar i = 0; i < NUM_CELLS; i++) begin : gCell
    localparam int BANK = i / BANK_SIZE;
    logic      cellClk;
    mcStrobe_t strobe;

    mc_ctrl uCtrl (
      .modeCfg  (cfgMode[2*i +: 2]),
      .typeCfg  (cfgType[2*i +: 2]),
      .sumA     (sumA[i]),
      .sumB     (sumB[i]),
      .specialPt(specialPt[i]),
      .bankClk  (bankClk[BANK]),
      .cellClk  (cellClk),
      .outEn    (pinOe[i]),
      .strobe   (strobe)
    );

    mc_datapath uData (
      .cellClk  (cellClk),
      .rstIn    (rstIn),
      .strobe   (strobe),
      .sumA     (sumA[i]),
      .invertCfg(cfgInvert[i]),
      .fbSumCfg (cfgFbSum[i]),
      .pinVal   (pinOut[i]),
      .fbVal    (fbOut[i])
    );

    always_comb begin
      if (rstIn == 1'b0) begin
        assert_oe_async_R6: assert (!cfgMode[2*i+1] || pinOe[i]);
        assert_oe_term_R7: assert (cfgMode[2*i+1] || (pinOe[i] == specialPt[i]));
      end
    end
  end
endmodule

// File: tb/sim_pld_macro_bank.sv
module sim_pld_macro_bank;
  localparam int N  = 16;
  localparam int BS = 8;
  localparam int NB = N / BS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rstIn;
  logic [NB-1:0]  bankClk;
  logic [N-1:0]   sumA, sumB, specialPt, cfgInvert, cfgFbSum;
  logic [2*N-1:0] cfgMode, cfgType;
  logic [N-1:0]   pinOut, pinOe, fbOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [N-1:0] mq;
  logic [N-1:0] asyncMask;
  logic [N-1:0] combMask;

  // {sumA, sumB} per row
  localparam logic [31:0] VEC [8] = '{
    32'hFFFF_0000, 32'h0F0F_F0F0, 32'hFFFF_FFFF, 32'h0000_FFFF,
    32'hAAAA_5555, 32'h0000_0000, 32'hFFFF_FFFF, 32'h3C3C_C3C3
  };

  pld_macro_bank #(.NUM_CELLS(N), .BANK_SIZE(BS)) u0 (
    .rstIn(rstIn), .bankClk(bankClk), .sumA(sumA), .sumB(sumB),
    .specialPt(specialPt), .cfgMode(cfgMode), .cfgType(cfgType),
    .cfgInvert(cfgInvert), .cfgFbSum(cfgFbSum),
    .pinOut(pinOut), .pinOe(pinOe), .fbOut(fbOut)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic nextBit(input int kind, input logic q, input logic a, input logic b);
    case (kind)
      0: return a;
      1: return a ? ~q : q;
      2: case ({a, b})
           2'b10: return 1'b1;
           2'b01: return 1'b0;
           2'b11: return ~q;
           default: return q;
         endcase
      default: case ({a, b})
           2'b10: return 1'b1;
           2'b01: return 1'b0;
           default: return q;
         endcase
    endcase
  endfunction

  function automatic logic [N-1:0] expPin();
    return ((mq & ~combMask) | (sumA & combMask)) ^ cfgInvert;
  endfunction

  function automatic logic [N-1:0] expFb();
    return (mq & ~cfgFbSum) | (sumA & cfgFbSum);
  endfunction

  task automatic pulseBanks(input logic [NB-1:0] m);
    @(negedge clk);
    bankClk = m;
    for (int i = 0; i < N; i++)
      if (!asyncMask[i] && m[i/BS]) mq[i] = nextBit(i % 4, mq[i], sumA[i], sumB[i]);
    @(negedge clk);
    bankClk = '0;
    #1;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstIn = 1'b1; bankClk = '0; sumA = '0; sumB = '0;
    specialPt = 16'hA5C3; cfgInvert = 16'hF0F0; cfgFbSum = '0;
    asyncMask = '0; combMask = '0; mq = '0;
    for (int i = 0; i < N; i++) begin
      cfgMode[2*i +: 2] = 2'b01;
      cfgType[2*i +: 2] = 2'(i % 4);
    end
    repeat (3) @(negedge clk);
    rstIn = 1'b0;
    #1;
    check("R11 reset state fb", fbOut, 16'h0000);
    check("R9 reset pin polarity", pinOut, cfgInvert);
    check("R7 oe from special term", pinOe, specialPt);

    // vector walk over all four storage types
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      sumA = VEC[r][31:16];
      sumB = VEC[r][15:0];
      pulseBanks(2'b11);
      check("R1/R2/R3/R4 register update", fbOut, expFb());
      check("R9 pin polarity", pinOut, expPin());
    end

    // only bank 0 clocked
    @(negedge clk);
    sumA = 16'hFFFF; sumB = 16'h0000;
    pulseBanks(2'b01);
    check("R5 bank 0 only", fbOut, expFb());
    sumA = 16'h0000; sumB = 16'hFFFF;
    pulseBanks(2'b10);
    check("R5 bank 1 only", fbOut, expFb());

    @(negedge clk);
    specialPt = 16'h5A3C;
    #1;
    check("R7 oe follows term", pinOe, specialPt);

    // cell 4 (D type) to per-cell clock
    @(negedge clk);
    specialPt = 16'h0000;
    cfgMode[9:8] = 2'b10;
    asyncMask[4] = 1'b1;
    #1;
    check("R6 oe forced in async", pinOe, specialPt | asyncMask);
    sumA = ~fbOut; sumB = 16'h0000;
    pulseBanks(2'b11);
    check("R6 bank clock ignored by async cell", fbOut, expFb());
    @(negedge clk);
    sumA[4] = ~mq[4];
    #1;
    specialPt[4] = 1'b1;
    mq[4] = sumA[4];
    #1;
    check("R6 per-cell clock", fbOut, expFb());
    check("R6 oe high with term high", pinOe, specialPt | asyncMask);
    @(negedge clk);
    specialPt[4] = 1'b0;
    #1;

    // cell 9 combinatorial
    @(negedge clk);
    cfgMode[19:18] = 2'b00;
    combMask[9] = 1'b1;
    sumA[9] = 1'b1;
    #1;
    check("R8 comb pin high", pinOut, expPin());
    sumA[9] = 1'b0;
    #1;
    check("R8 comb pin low", pinOut, expPin());
    sumA = 16'hFFFF; sumB = 16'h0000;
    pulseBanks(2'b11);
    check("R8 comb cell register still clocked", fbOut, expFb());
    check("R9 pin after comb", pinOut, expPin());

    // feedback source select
    @(negedge clk);
    cfgFbSum = 16'h0004;
    sumA[2] = ~mq[2];
    #1;
    check("R10 fb from sum", fbOut, expFb());
    sumA[2] = mq[2];
    cfgFbSum = 16'h0000;
    #1;
    check("R10 fb from register", fbOut, expFb());

    // reset with registers holding ones
    sumA = 16'hFFFF; sumB = 16'h0000;
    pulseBanks(2'b11);
    @(negedge clk);
    rstIn = 1'b1;
    mq = '0;
    #1;
    check("R11 async clear", fbOut, 16'h0000);
    check("R11 pin after clear", pinOut, expPin());
    finishRun();
  end
endmodule